// File: doc/BRIEF.md
# Input Cell Queue Controller

This block is the per-port input queue that sits between a link receiver and a cell switch. Cells of 53 bytes arrive one byte per clock. Each accepted cell is kept whole in a first-in-first-out store. While the cell is being written, its header fields are decoded. Selected low bits of the path and circuit identifiers form an index into an external translation table. That table returns three things: a multicast destination vector, an outgoing path identifier and an outgoing circuit identifier. All three are stored alongside the cell.

The switch runs the outgoing side in slots.

- **Poll:** a poll pulse asks the queue what it holds. One cycle later the queue presents a valid flag and the destination vector of its oldest cell.
- **Grant:** a grant pulse, given while that offer stands, starts the transfer. The oldest cell streams out one byte per cycle with its header rewritten, and is then removed.
- **No grant:** the oldest cell stays put and is offered again at the next poll. Every later cell waits behind it.

When all cell slots are occupied, the queue raises a full flag. Any cell that begins arriving in that state is discarded whole and counted.

Top module: `cell_queue_ctrl`

## Requirements
- R1: After synchronous reset `sw_valid`, `sw_xfer`, `q_full` are low, `sw_dvec` is zero and `drop_count` is zero.
- R2: A cell starts with a byte where `rx_valid` and `rx_sop` are both high and spans 53 consecutive `rx_valid` bytes. Bytes with `rx_valid` high that do not belong to a started cell are ignored and store nothing.
- R3: The header uses the user-side layout: byte0 = {GFC[3:0], VPI[7:4]}, byte1 = {VPI[3:0], VCI[15:12]}, byte2 = VCI[11:4], byte3 = {VCI[3:0], PT[2:0], CLP}. During header byte 3, `lut_idx` = {VPI[IDX_VP-1:0], VCI[IDX_VC-1:0]}. In that same cycle the table outputs `lut_dvec`, `lut_vpi` and `lut_vci` are captured for the cell.
- R4: A poll taken while no transfer runs and no grant is accepted sets, from the next cycle, `sw_valid` to "queue not empty" and `sw_dvec` to the oldest cell's vector (zero when empty).
- R5: A grant taken while `sw_valid` is high and no transfer runs has these effects:
  - From the next cycle, `sw_xfer` is high for exactly 53 consecutive cycles, carrying bytes 0..52 on `sw_byte`, and `sw_valid` falls.
  - Bytes 0..3 carry the R3 layout with GFC and PT/CLP kept and VPI/VCI replaced by the captured outgoing values.
  - Bytes 4..52 are sent as received.
- R6: A transferred cell is removed. Cells leave in arrival order.
- R7: Without a grant, `sw_valid` and `sw_dvec` hold their values, and later polls offer the same oldest cell again.
- R8: Polls and grants that arrive while `sw_xfer` is high are ignored.
- R9: A grant while `sw_valid` is low starts no transfer.
- R10: `q_full` is high while DEPTH cells are stored. A cell whose first byte arrives while `q_full` is high is discarded entirely, and `drop_count` rises by one (saturating).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive byte present |
| rx_sop | input | 1 | Receive byte is the first of a cell |
| rx_byte | input | 8 | Receive data byte |
| lut_idx | output | IDX_VP+IDX_VC | Translation table index |
| lut_dvec | input | NPORT | Destination vector from the table |
| lut_vpi | input | 8 | Outgoing path identifier from the table |
| lut_vci | input | 16 | Outgoing circuit identifier from the table |
| q_full | output | 1 | All cell slots occupied |
| drop_count | output | DROP_W | Saturating count of discarded cells |
| sw_poll | input | 1 | Slot poll from the switch |
| sw_grant | input | 1 | Data strobe: switch accepts the offered cell |
| sw_valid | output | 1 | A cell is being offered |
| sw_dvec | output | NPORT | Destination vector of the offered cell |
| sw_xfer | output | 1 | Cell byte on `sw_byte` |
| sw_byte | output | 8 | Outgoing cell byte |

## Verification
The first pattern is a single cell polled and granted at once. It shows that the header is rewritten and the payload is delivered intact.

The second pattern has two cells queued, with polls left ungranted for many cycles and a grant that arrives before any poll. This separates a queue that holds its head from one that advances or drops it.

Polls and grants injected in the middle of a transfer show whether the transfer is ever cut short or re-armed.

Finally, the store is filled completely and one more cell is sent before draining. This shows that the overflow cell is counted and never appears among the sixteen delivered cells, which leave in order.

// File: rtl/iq_pkg.sv
package iq_pkg;

    localparam int CELL_BYTES = 53;
    localparam int HDR_BYTES  = 4;
    localparam int PAY_BYTES  = CELL_BYTES - HDR_BYTES;
    localparam int POS_W      = $clog2(CELL_BYTES);
    localparam int PAY_W      = $clog2(PAY_BYTES);

    // Outgoing header kept per stored cell
    typedef struct packed {
        logic [3:0]  gfc;
        logic [7:0]  vpi;
        logic [15:0] vci;
        logic [3:0]  ptc;   // PT and CLP together
    } hdr_t;

    // Rebuild header byte k from the stored fields
    function automatic logic [7:0] hdr_byte(input hdr_t h, input logic [1:0] k);
        logic [7:0] b;
        case (k)
            2'd0:    b = {h.gfc, h.vpi[7:4]};
            2'd1:    b = {h.vpi[3:0], h.vci[15:12]};
            2'd2:    b = h.vci[11:4];
            default: b = {h.vci[3:0], h.ptc};
        endcase
        return b;
    endfunction

endpackage

// File: rtl/iq_rx_capture.sv
module iq_rx_capture
    import iq_pkg::*;
#(
    parameter int IDX_VP = 2,
    parameter int IDX_VC = 2,
    parameter int DROP_W = 16,
    localparam int IDX_W = IDX_VP + IDX_VC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic              rx_sop,
    input  logic [7:0]        rx_byte,
    input  logic              full,
    input  logic [7:0]        lut_vpi,
    input  logic [15:0]       lut_vci,
    output logic [IDX_W-1:0]  lut_idx,
    output logic              hdr_we,
    output hdr_t              hdr_new,
    output logic              pay_we,
    output logic [PAY_W-1:0]  pay_idx,
    output logic              cell_done,
    output logic [DROP_W-1:0] drop_count
);

    logic [POS_W-1:0] pos_q;
    logic             active_q;
    logic [7:0]       b0_q, b1_q, b2_q;
    logic [POS_W-1:0] cur_pos;
    logic             take;
    logic [7:0]       vpi_seen;
    logic [15:0]      vci_seen;

    always_comb begin
        cur_pos   = rx_sop ? '0 : pos_q;
        take      = rx_valid && (rx_sop ? !full : active_q);
        vpi_seen  = {b0_q[3:0], b1_q[7:4]};
        vci_seen  = {b1_q[3:0], b2_q, rx_byte[7:4]};
        lut_idx   = {vpi_seen[IDX_VP-1:0], vci_seen[IDX_VC-1:0]};
        hdr_we    = take && (cur_pos == POS_W'(HDR_BYTES - 1));
        hdr_new   = '{gfc: b0_q[7:4], vpi: lut_vpi, vci: lut_vci, ptc: rx_byte[3:0]};
        pay_we    = take && (cur_pos >= POS_W'(HDR_BYTES));
        pay_idx   = PAY_W'(cur_pos - POS_W'(HDR_BYTES));
        cell_done = take && (cur_pos == POS_W'(CELL_BYTES - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q      <= '0;
            active_q   <= 1'b0;
            drop_count <= '0;
        end else if (rx_valid) begin
            if (rx_sop) begin
                active_q <= !full;
                pos_q    <= POS_W'(1);
                if (full && (drop_count != '1))
                    drop_count <= drop_count + 1'b1;
            end else if (active_q) begin
                if (pos_q == POS_W'(CELL_BYTES - 1)) begin
                    active_q <= 1'b0;
                    pos_q    <= '0;
                end else begin
                    pos_q <= pos_q + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b0_q <= '0;
            b1_q <= '0;
            b2_q <= '0;
        end else if (take) begin
            case (cur_pos)
                POS_W'(0): b0_q <= rx_byte;
                POS_W'(1): b1_q <= rx_byte;
                POS_W'(2): b2_q <= rx_byte;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/iq_cell_store.sv
module iq_cell_store
    import iq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int NPORT = 5,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hdr_we,
    input  hdr_t             hdr_in,
    input  logic [NPORT-1:0] dvec_in,
    input  logic             pay_we,
    input  logic [PAY_W-1:0] pay_idx,
    input  logic [7:0]       pay_in,
    input  logic             push,
    input  logic             pop,
    input  logic [PAY_W-1:0] rd_idx,
    output logic             full,
    output logic             empty,
    output hdr_t             head_hdr,
    output logic [NPORT-1:0] head_dvec,
    output logic [7:0]       head_byte
);

    hdr_t             hdr_mem [DEPTH];
    logic [NPORT-1:0] dv_mem  [DEPTH];
    logic [7:0]       pay_mem [DEPTH][PAY_BYTES];

    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (hdr_we) begin
            hdr_mem[wr_ptr] <= hdr_in;
            dv_mem[wr_ptr]  <= dvec_in;
        end
        if (pay_we)
            pay_mem[wr_ptr][pay_idx] <= pay_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= next_ptr(wr_ptr);
            if (pop)  rd_ptr <= next_ptr(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        full      = (count == CNT_W'(DEPTH));
        empty     = (count == '0);
        head_hdr  = hdr_mem[rd_ptr];
        head_dvec = dv_mem[rd_ptr];
        head_byte = (rd_idx < PAY_W'(PAY_BYTES)) ? pay_mem[rd_ptr][rd_idx] : 8'h00;
    end

endmodule

// File: rtl/iq_tx_offer.sv
module iq_tx_offer
    import iq_pkg::*;
#(
    parameter int NPORT = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             poll,
    input  logic             grant,
    input  logic             empty,
    input  logic [NPORT-1:0] head_dvec,
    input  hdr_t             head_hdr,
    input  logic [7:0]       head_byte,
    output logic             sw_valid,
    output logic [NPORT-1:0] sw_dvec,
    output logic             sw_xfer,
    output logic [7:0]       sw_byte,
    output logic [PAY_W-1:0] rd_idx,
    output logic             pop
);

    logic [POS_W-1:0] pos_q;
    logic             xfer_q, offer_q;
    logic [NPORT-1:0] dvec_q;
    logic             last;

    assign last = (pos_q == POS_W'(CELL_BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= '0;
            xfer_q  <= 1'b0;
            offer_q <= 1'b0;
            dvec_q  <= '0;
        end else if (xfer_q) begin
            if (last) begin
                xfer_q <= 1'b0;
                pos_q  <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end else if (grant && offer_q) begin
            xfer_q  <= 1'b1;
            pos_q   <= '0;
            offer_q <= 1'b0;
            dvec_q  <= '0;
        end else if (poll) begin
            offer_q <= !empty;
            dvec_q  <= empty ? '0 : head_dvec;
        end
    end

    always_comb begin
        sw_valid = offer_q;
        sw_dvec  = dvec_q;
        sw_xfer  = xfer_q;
        pop      = xfer_q && last;
        rd_idx   = PAY_W'(pos_q - POS_W'(HDR_BYTES));
        sw_byte  = (pos_q < POS_W'(HDR_BYTES)) ? hdr_byte(head_hdr, pos_q[1:0]) : head_byte;
    end

endmodule

// File: rtl/cell_queue_ctrl.sv
module cell_queue_ctrl
    import iq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int NPORT  = 5,
    parameter int IDX_VP = 2,
    parameter int IDX_VC = 2,
    parameter int DROP_W = 16,
    localparam int IDX_W = IDX_VP + IDX_VC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic              rx_sop,
    input  logic [7:0]        rx_byte,
    output logic [IDX_W-1:0]  lut_idx,
    input  logic [NPORT-1:0]  lut_dvec,
    input  logic [7:0]        lut_vpi,
    input  logic [15:0]       lut_vci,
    output logic              q_full,
    output logic [DROP_W-1:0] drop_count,
    input  logic              sw_poll,
    input  logic              sw_grant,
    output logic              sw_valid,
    output logic [NPORT-1:0]  sw_dvec,
    output logic              sw_xfer,
    output logic [7:0]        sw_byte
);

    logic             hdr_we, pay_we, cell_done, pop, q_empty;
    hdr_t             hdr_new, head_hdr;
    logic [PAY_W-1:0] pay_idx, rd_idx;
    logic [NPORT-1:0] head_dvec;
    logic [7:0]       head_byte;

    iq_rx_capture #(.IDX_VP(IDX_VP), .IDX_VC(IDX_VC), .DROP_W(DROP_W)) u_rx (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_byte(rx_byte),
        .full(q_full), .lut_vpi(lut_vpi), .lut_vci(lut_vci), .lut_idx(lut_idx),
        .hdr_we(hdr_we), .hdr_new(hdr_new), .pay_we(pay_we), .pay_idx(pay_idx),
        .cell_done(cell_done), .drop_count(drop_count)
    );

    iq_cell_store #(.DEPTH(DEPTH), .NPORT(NPORT)) u_store (
        .clk(clk), .rst(rst), .hdr_we(hdr_we), .hdr_in(hdr_new), .dvec_in(lut_dvec),
        .pay_we(pay_we), .pay_idx(pay_idx), .pay_in(rx_byte), .push(cell_done),
        .pop(pop), .rd_idx(rd_idx), .full(q_full), .empty(q_empty),
        .head_hdr(head_hdr), .head_dvec(head_dvec), .head_byte(head_byte)
    );

    iq_tx_offer #(.NPORT(NPORT)) u_tx (
        .clk(clk), .rst(rst), .poll(sw_poll), .grant(sw_grant), .empty(q_empty),
        .head_dvec(head_dvec), .head_hdr(head_hdr), .head_byte(head_byte),
        .sw_valid(sw_valid), .sw_dvec(sw_dvec), .sw_xfer(sw_xfer), .sw_byte(sw_byte),
        .rd_idx(rd_idx), .pop(pop)
    );

endmodule

// File: rtl/cell_queue_ctrl_chk.sv
module cell_queue_ctrl_chk
    import iq_pkg::*;
#(
    parameter int NPORT  = 5,
    parameter int DROP_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_valid,
    input logic              rx_sop,
    input logic              q_full,
    input logic              q_empty,
    input logic [DROP_W-1:0] drop_count,
    input logic              sw_poll,
    input logic              sw_grant,
    input logic              sw_valid,
    input logic [NPORT-1:0]  sw_dvec,
    input logic              sw_xfer
);

    logic [7:0] xcnt;

    always_ff @(posedge clk) begin
        if (rst)          xcnt <= '0;
        else if (sw_xfer) xcnt <= xcnt + 1'b1;
        else              xcnt <= '0;
    end

    AST_XFER_BOUND: assert property (@(posedge clk) disable iff (rst)
        sw_xfer |-> (xcnt < 8'(CELL_BYTES)));                                    // R5
    AST_XFER_FULL_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_xfer) |-> (xcnt == 8'(CELL_BYTES)));                            // R5
    AST_GRANT_STARTS: assert property (@(posedge clk) disable iff (rst)
        (sw_grant && sw_valid && !sw_xfer) |=> (sw_xfer && !sw_valid));          // R5
    AST_NO_OFFER_IN_XFER: assert property (@(posedge clk) disable iff (rst)
        sw_xfer |-> !sw_valid);                                                  // R8
    AST_NO_GRANT_NO_XFER: assert property (@(posedge clk) disable iff (rst)
        (!sw_xfer && !sw_valid) |=> !sw_xfer);                                   // R9
    AST_POLL_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (sw_poll && !sw_xfer && !(sw_grant && sw_valid) && q_empty) |=> !sw_valid);  // R4
    AST_POLL_LOADED: assert property (@(posedge clk) disable iff (rst)
        (sw_poll && !sw_xfer && !(sw_grant && sw_valid) && !q_empty) |=> sw_valid);  // R4
    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (rst)
        (!sw_poll && !sw_grant && !sw_xfer) |=> ($stable(sw_valid) && $stable(sw_dvec)));  // R7
    AST_DROP_COUNT: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_sop && q_full && (drop_count != '1)) |=> (drop_count == $past(drop_count) + 1'b1));  // R10
    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        q_full |-> !q_empty);                                                    // R10

endmodule

bind cell_queue_ctrl cell_queue_ctrl_chk #(.NPORT(NPORT), .DROP_W(DROP_W)) u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sop(rx_sop), .q_full(q_full),
    .q_empty(q_empty), .drop_count(drop_count), .sw_poll(sw_poll), .sw_grant(sw_grant),
    .sw_valid(sw_valid), .sw_dvec(sw_dvec), .sw_xfer(sw_xfer)
);

// File: tb/cell_queue_ctrl_test.sv
`timescale 1ns/1ps
module cell_queue_ctrl_test;

    localparam int DEPTH = 16;
    localparam int NPORT = 5;
    localparam int NB    = 53;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0, rx_sop = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [3:0]  lut_idx;
    logic [4:0]  lut_dvec;
    logic [7:0]  lut_vpi;
    logic [15:0] lut_vci;
    logic        q_full;
    logic [15:0] drop_count;
    logic        sw_poll = 1'b0, sw_grant = 1'b0;
    logic        sw_valid, sw_xfer;
    logic [4:0]  sw_dvec;
    logic [7:0]  sw_byte;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_b[$];
    int mon_n = 0;
    logic prev_xfer = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [4:0] tb_dv(input logic [3:0] i);
        return {1'b0, i} + 5'd1;
    endfunction
    function automatic logic [7:0] tb_vpi(input logic [3:0] i);
        return 8'h40 + {4'h0, i};
    endfunction
    function automatic logic [15:0] tb_vci(input logic [3:0] i);
        return 16'h0023 + 16'h0100 * {12'h0, i};
    endfunction

    assign lut_dvec = tb_dv(lut_idx);
    assign lut_vpi  = tb_vpi(lut_idx);
    assign lut_vci  = tb_vci(lut_idx);

    cell_queue_ctrl uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_byte(rx_byte),
        .lut_idx(lut_idx), .lut_dvec(lut_dvec), .lut_vpi(lut_vpi), .lut_vci(lut_vci),
        .q_full(q_full), .drop_count(drop_count), .sw_poll(sw_poll), .sw_grant(sw_grant),
        .sw_valid(sw_valid), .sw_dvec(sw_dvec), .sw_xfer(sw_xfer), .sw_byte(sw_byte)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] dv_of(input logic [7:0] vpi, input logic [15:0] vci);
        return tb_dv({vpi[1:0], vci[1:0]});
    endfunction

    // Driver: sends a cell and pushes its expected translated form
    task automatic send_cell(input logic [3:0] gfc, input logic [7:0] vpi,
                             input logic [15:0] vci, input logic [3:0] ptc,
                             input logic [7:0] seed, input bit keep);
        logic [7:0] raw [NB];
        logic [3:0] idx;
        logic [7:0] nv;
        logic [15:0] nc;
        idx = {vpi[1:0], vci[1:0]};
        nv = tb_vpi(idx);
        nc = tb_vci(idx);
        raw[0] = {gfc, vpi[7:4]};
        raw[1] = {vpi[3:0], vci[15:12]};
        raw[2] = vci[11:4];
        raw[3] = {vci[3:0], ptc};
        raw[4] = seed ^ 8'h5A;
        for (int k = 5; k < NB; k++) raw[k] = seed + 8'(k);
        if (keep) begin
            exp_b.push_back({gfc, nv[7:4]});
            exp_b.push_back({nv[3:0], nc[15:12]});
            exp_b.push_back(nc[11:4]);
            exp_b.push_back({nc[3:0], ptc});
            for (int k = 4; k < NB; k++) exp_b.push_back(raw[k]);
        end
        for (int k = 0; k < NB; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sop   = (k == 0);
            rx_byte  = raw[k];
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sop   = 1'b0;
    endtask

    task automatic pulse_poll();
        @(negedge clk); sw_poll = 1'b1;
        @(negedge clk); sw_poll = 1'b0;
    endtask

    task automatic pulse_grant();
        @(negedge clk); sw_grant = 1'b1;
        @(negedge clk); sw_grant = 1'b0;
    endtask

    task automatic wait_xfer_done();
        while (sw_xfer) @(negedge clk);
    endtask

    // Monitor: compares every outgoing byte with the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (sw_xfer) begin
                if (exp_b.size() == 0) check("R5 unexpected byte", 32'(sw_byte), 32'hFFFF);
                else check("R5 byte", 32'(sw_byte), 32'(exp_b.pop_front()));
                mon_n++;
            end else if (prev_xfer) begin
                check("R5 cell length", 32'(mon_n), 32'(NB));
                mon_n = 0;
            end
            prev_xfer = sw_xfer;
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 sw_valid", 32'(sw_valid), 0);
        check("R1 sw_xfer", 32'(sw_xfer), 0);
        check("R1 q_full", 32'(q_full), 0);
        check("R1 sw_dvec", 32'(sw_dvec), 0);
        check("R1 drop_count", 32'(drop_count), 0);

        // R2: stray bytes without a start marker are ignored
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); rx_valid = 1'b1; rx_sop = 1'b0; rx_byte = 8'(k);
        end
        @(negedge clk); rx_valid = 1'b0;
        pulse_poll();
        check("R2 stray bytes", 32'(sw_valid), 0);
        check("R4 empty dvec", 32'(sw_dvec), 0);

        // Single cell: lookup, offer, transfer
        send_cell(4'h3, 8'h9E, 16'h1235, 4'hA, 8'h10, 1'b1);
        pulse_poll();
        check("R4 offer valid", 32'(sw_valid), 1);
        check("R3 dvec", 32'(sw_dvec), 32'(dv_of(8'h9E, 16'h1235)));
        pulse_grant();
        check("R5 xfer starts", 32'(sw_xfer), 1);
        check("R5 valid drops", 32'(sw_valid), 0);
        pulse_poll();
        pulse_grant();
        check("R8 still xfer", 32'(sw_xfer), 1);
        wait_xfer_done();
        check("R8 poll ignored", 32'(sw_valid), 0);
        check("R5 all bytes", 32'(exp_b.size()), 0);

        // Head-of-line hold with two cells
        send_cell(4'h1, 8'h21, 16'h4442, 4'h2, 8'h30, 1'b1);
        send_cell(4'h7, 8'h13, 16'h0007, 4'h5, 8'h70, 1'b1);
        pulse_grant();
        check("R9 grant w/o offer", 32'(sw_xfer), 0);
        pulse_poll();
        check("R7 first offer", 32'(sw_dvec), 32'(dv_of(8'h21, 16'h4442)));
        repeat (20) @(negedge clk);
        check("R7 held valid", 32'(sw_valid), 1);
        check("R7 held dvec", 32'(sw_dvec), 32'(dv_of(8'h21, 16'h4442)));
        pulse_poll();
        check("R7 re-offer", 32'(sw_dvec), 32'(dv_of(8'h21, 16'h4442)));
        pulse_grant();
        wait_xfer_done();
        pulse_poll();
        check("R6 next in order", 32'(sw_dvec), 32'(dv_of(8'h13, 16'h0007)));
        pulse_grant();
        wait_xfer_done();

        // Fill, overflow, drain
        for (int i = 0; i < DEPTH; i++)
            send_cell(4'(i), 8'h10 + 8'(i), 16'h0200 + 16'(i * 5), 4'(i + 1), 8'(i * 11), 1'b1);
        check("R10 full", 32'(q_full), 1);
        send_cell(4'hF, 8'hFF, 16'hFFFF, 4'hF, 8'hEE, 1'b0);
        check("R10 drop count", 32'(drop_count), 1);
        for (int i = 0; i < DEPTH; i++) begin
            pulse_poll();
            check("R6 drain dvec", 32'(sw_dvec),
                  32'(dv_of(8'h10 + 8'(i), 16'h0200 + 16'(i * 5))));
            pulse_grant();
            wait_xfer_done();
        end
        check("R10 not full", 32'(q_full), 0);
        pulse_poll();
        check("R10 dropped cell absent", 32'(sw_valid), 0);
        check("R6 scoreboard empty", 32'(exp_b.size()), 0);
        finish_run();
    end

endmodule